// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It combines two predictors and a third table that chooses between them. The local predictor keeps one history register for each branch slot, indexed by the branch address. That history selects a saturating counter in a table of local counters. The global predictor uses one shared path history register to select a counter in a table of global counters. A choice table, indexed by the same global history, decides which of the two guesses is reported.

A front end issues a lookup with the branch PC. In the same cycle it receives the predicted direction and a checkpoint. Only the global history moves at lookup time, and it moves speculatively. The local histories and all three counter tables change only when the resolved branch comes back on the update port together with its checkpoint. A squash hands a checkpoint back to rewind the global history. An unconditional branch receives a checkpoint and advances the global history by a taken bit.

The lookup and unconditional ports use valid/ready. A source whose valid sees ready low has not been served and must hold its request. Squash and update carry only a valid and are always accepted, because they bring resolved state that must not wait. All outputs are combinational from registered state, so a request is answered in the cycle it is accepted.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every counter holds its threshold and every history is zero. A lookup at that point predicts not taken and returns checkpoint 0, and both ready outputs are high while no squash or update is valid.
- R2: The local history slot is ((PC >> SHIFT) mod local-slot count), so the low SHIFT address bits never affect a prediction. The slot's history value, masked to its width, selects the local counter.
- R3: A counter of width w predicts taken only when its value is strictly greater than 2^(w-1)-1. With 2-bit counters the values 2 and 3 predict taken, and 0 and 1 predict not taken.
- R4: The checkpoint has three flag bits and a history field. Bit 0 is 1 when the global guess was chosen. Bit 1 is the global guess and bit 2 is the local guess. The bits above hold the global history from before the lookup. The reported direction is the global guess when bit 0 is 1 and the local guess otherwise.
- R5: An accepted lookup shifts its predicted direction into bit 0 of the global history and drops the top bit. The global history selects both the global counter and the choice counter. A lookup never changes any counter or any local history.
- R6: A squash loads the global history from the history field of the supplied checkpoint.
- R7: The unconditional checkpoint output always shows the current global history with all three flag bits zero. An accepted unconditional branch shifts a 1 into the global history.
- R8: An update steps two counters one place toward the outcome, saturating at 0 and at the maximum: the local counter chosen by the PC's current local history, and the global counter chosen by the checkpoint history. The PC's local history then shifts in the outcome. The global history becomes the checkpoint history with the outcome shifted in.
- R9: An update changes the choice counter at the checkpoint history only when the local and global flags differ. It counts up when the global guess matched the outcome and down otherwise, saturating at both ends.
- R10: Squash has priority over update, update over lookup, and lookup over an unconditional branch. Lookup ready is low when a squash or update is valid. Unconditional ready is additionally low when a lookup is valid. A request without ready has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_pc | input | PC_W | Branch address for lookup |
| lk_taken | output | 1 | Predicted direction |
| lk_ckpt | output | GHIST_BITS+3 | Checkpoint for this lookup |
| unc_valid | input | 1 | Unconditional branch notify |
| unc_ready | output | 1 | Unconditional notify accepted |
| unc_ckpt | output | GHIST_BITS+3 | Checkpoint for the unconditional branch |
| upd_valid | input | 1 | Resolved branch training request |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_ckpt | input | GHIST_BITS+3 | Checkpoint returned with the branch |
| sq_valid | input | 1 | Squash request |
| sq_ckpt | input | GHIST_BITS+3 | Checkpoint to restore from |

## Verification
A wrong global history shows in the next cycle, because the checkpoint outputs carry it directly. A wrong counter step or a wrong local history stays hidden until a later lookup lands on the damaged entry and reports the wrong direction or the wrong flag bits. The bench therefore keeps a full behavioural copy of every table and compares the outputs on every cycle. It uses a few recurring addresses with patterned outcomes, so damaged entries are revisited within tens of cycles.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // checkpoint flag positions; the global history sits above them
  localparam int CK_USED_GLOBAL = 0;
  localparam int CK_GLOBAL_PRED = 1;
  localparam int CK_LOCAL_PRED  = 2;
  localparam int CK_FLAGS       = 3;

  function automatic int ctr_threshold(input int w);
    return (1 << (w - 1)) - 1;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hi,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] THR = CTR_W'(tp_pkg::ctr_threshold(CTR_W));
  localparam logic [CTR_W-1:0] MAXV = '1;

  logic [CTR_W-1:0] ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= THR;
    end else if (wr_en) begin
      if (wr_up && ctr_q[wr_idx] != MAXV) ctr_q[wr_idx] <= ctr_q[wr_idx] + 1'b1;
      else if (!wr_up && ctr_q[wr_idx] != '0) ctr_q[wr_idx] <= ctr_q[wr_idx] - 1'b1;
    end
  end

  assign rd_hi = ctr_q[rd_idx] > THR;

  // R8 / R9: saturation at both ends and single steps
  p_sat_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && ctr_q[wr_idx] == MAXV) |=> ctr_q[$past(wr_idx)] == MAXV);
  p_sat_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && ctr_q[wr_idx] == '0) |=> ctr_q[$past(wr_idx)] == '0);
  p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && ctr_q[wr_idx] != MAXV) |=>
      ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) + 1'b1);
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W = 4,
  parameter int H_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [H_W-1:0]   rd_a_val,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [H_W-1:0]   rd_b_val,
  input  logic             wr_en,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [H_W-1:0] hist_q [DEPTH];

  // writes always go to the slot on read port b
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[rd_b_idx] <= H_W'({hist_q[rd_b_idx], wr_bit});
    end
  end

  assign rd_a_val = hist_q[rd_a_idx];
  assign rd_b_val = hist_q[rd_b_idx];

  // R8: the resolved slot gains the outcome as its newest bit
  p_local_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hist_q[$past(rd_b_idx)][0] == $past(wr_bit));
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int PC_W       = 32,
  parameter int SHIFT      = 2,
  parameter int LHT_LOG2   = 4,
  parameter int LHIST_BITS = 6,
  parameter int LCTR_W     = 2,
  parameter int GHIST_BITS = 6,
  parameter int GCTR_W     = 2,
  parameter int CHOICE_W   = 2,
  localparam int CK_W      = GHIST_BITS + tp_pkg::CK_FLAGS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [CK_W-1:0] lk_ckpt,
  input  logic            unc_valid,
  output logic            unc_ready,
  output logic [CK_W-1:0] unc_ckpt,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [CK_W-1:0] upd_ckpt,
  input  logic            sq_valid,
  input  logic [CK_W-1:0] sq_ckpt
);
  import tp_pkg::*;

  logic [GHIST_BITS-1:0] ghr_q;
  logic [LHT_LOG2-1:0]   lk_slot, upd_slot;
  logic [LHIST_BITS-1:0] lk_lhist, upd_lhist;
  logic                  loc_pred, glob_pred, use_glob;
  logic [GHIST_BITS-1:0] upd_gh, sq_gh;
  logic                  upd_loc, upd_glob;
  logic                  lk_fire, unc_fire;

  assign lk_slot   = LHT_LOG2'(lk_pc >> SHIFT);
  assign upd_slot  = LHT_LOG2'(upd_pc >> SHIFT);
  assign upd_gh    = GHIST_BITS'(upd_ckpt >> CK_FLAGS);
  assign sq_gh     = GHIST_BITS'(sq_ckpt >> CK_FLAGS);
  assign upd_loc   = upd_ckpt[CK_LOCAL_PRED];
  assign upd_glob  = upd_ckpt[CK_GLOBAL_PRED];

  tp_hist_table #(.IDX_W(LHT_LOG2), .H_W(LHIST_BITS)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_slot), .rd_a_val(lk_lhist),
    .rd_b_idx(upd_slot), .rd_b_val(upd_lhist),
    .wr_en(upd_valid), .wr_bit(upd_taken)
  );

  tp_ctr_table #(.IDX_W(LHIST_BITS), .CTR_W(LCTR_W)) u_local (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lhist), .rd_hi(loc_pred),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_BITS), .CTR_W(GCTR_W)) u_global (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr_q), .rd_hi(glob_pred),
    .wr_en(upd_valid), .wr_idx(upd_gh), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_BITS), .CTR_W(CHOICE_W)) u_choice (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr_q), .rd_hi(use_glob),
    .wr_en(upd_valid && (upd_loc != upd_glob)),
    .wr_idx(upd_gh), .wr_up(upd_glob == upd_taken)
  );

  // arbitration: squash > update > lookup > unconditional
  assign lk_ready  = !sq_valid && !upd_valid;
  assign unc_ready = lk_ready && !lk_valid;
  assign lk_fire   = lk_valid && lk_ready;
  assign unc_fire  = unc_valid && unc_ready;

  assign lk_taken = use_glob ? glob_pred : loc_pred;
  assign lk_ckpt  = {ghr_q, loc_pred, glob_pred, use_glob};
  assign unc_ckpt = {ghr_q, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n)         ghr_q <= '0;
    else if (sq_valid)  ghr_q <= sq_gh;
    else if (upd_valid) ghr_q <= GHIST_BITS'({upd_gh, upd_taken});
    else if (lk_fire)   ghr_q <= GHIST_BITS'({ghr_q, lk_taken});
    else if (unc_fire)  ghr_q <= GHIST_BITS'({ghr_q, 1'b1});
  end

  p_squash_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> ghr_q == $past(sq_gh));
  p_lookup_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> ghr_q[0] == $past(lk_taken));
  p_unc_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unc_fire |=> ghr_q[0]);
  p_update_rebuild_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !sq_valid) |=> ghr_q[0] == $past(upd_taken));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq_valid && !upd_valid && !lk_valid && !unc_valid) |=> $stable(ghr_q));
endmodule

// File: tb/tournament_predictor_tb.sv
module tournament_predictor_tb;
  localparam int CLK_P = 10;
  localparam int PC_W = 32;
  localparam int GH = 6;
  localparam int CK_W = GH + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, unc_valid = 0, upd_valid = 0, sq_valid = 0, upd_taken = 0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic [CK_W-1:0] upd_ckpt = '0, sq_ckpt = '0;
  logic lk_ready, unc_ready, lk_taken;
  logic [CK_W-1:0] lk_ckpt, unc_ckpt;

  always #(CLK_P/2) clk = ~clk;

  tournament_predictor u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .lk_taken(lk_taken), .lk_ckpt(lk_ckpt),
    .unc_valid(unc_valid), .unc_ready(unc_ready), .unc_ckpt(unc_ckpt),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_ckpt(upd_ckpt),
    .sq_valid(sq_valid), .sq_ckpt(sq_ckpt)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_lht[16];
  int m_lc[64];
  int m_gc[64];
  int m_ch[64];
  int m_ghr;
  int pq_pc[$];
  int pq_ck[$];

  function automatic int sat(int v, bit up);
    if (up) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction
  function automatic int e_loc(int pc);  return (m_lc[m_lht[(pc >> 2) & 15]] > 1) ? 1 : 0; endfunction
  function automatic int e_glob();       return (m_gc[m_ghr] > 1) ? 1 : 0; endfunction
  function automatic int e_use();        return (m_ch[m_ghr] > 1) ? 1 : 0; endfunction
  function automatic int e_pred(int pc); return (e_use() != 0) ? e_glob() : e_loc(pc); endfunction
  function automatic int e_ck(int pc);
    return (m_ghr << 3) | (e_loc(pc) << 2) | (e_glob() << 1) | e_use();
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    int pc, e_lr, p, upc, uck, t, si, li, gi, l, g;
    #1;
    pc   = int'(lk_pc);
    e_lr = (!sq_valid && !upd_valid) ? 1 : 0;
    chk("R10 lk_ready", int'(lk_ready), e_lr);
    chk("R10 unc_ready", int'(unc_ready), (e_lr != 0 && !lk_valid) ? 1 : 0);
    chk("R2 R3 R9 lk_taken", int'(lk_taken), e_pred(pc));
    chk("R4 R5 R8 lk_ckpt", int'(lk_ckpt), e_ck(pc));
    chk("R6 R7 unc_ckpt", int'(unc_ckpt), m_ghr << 3);
    if (lk_valid && e_lr != 0) begin
      pq_pc.push_back(pc);
      pq_ck.push_back(e_ck(pc));
    end
    p = e_pred(pc);
    @(posedge clk);
    upc = int'(upd_pc); uck = int'(upd_ckpt); t = int'(upd_taken);
    if (sq_valid)            m_ghr = int'(sq_ckpt) >> 3;
    else if (upd_valid)      m_ghr = (((uck >> 3) << 1) | t) & 63;
    else if (lk_valid)       m_ghr = ((m_ghr << 1) | p) & 63;
    else if (unc_valid)      m_ghr = ((m_ghr << 1) | 1) & 63;
    if (upd_valid) begin
      si = (upc >> 2) & 15;
      li = m_lht[si];
      gi = uck >> 3;
      l = (uck >> 2) & 1;
      g = (uck >> 1) & 1;
      m_lc[li] = sat(m_lc[li], t != 0);
      m_gc[gi] = sat(m_gc[gi], t != 0);
      if (l != g) m_ch[gi] = sat(m_ch[gi], g == t);
      m_lht[si] = ((m_lht[si] << 1) | t) & 63;
    end
    @(negedge clk);
  endtask

  task automatic do_lookup(int pc);
    lk_valid = 1; lk_pc = PC_W'(pc);
    step();
    lk_valid = 0;
  endtask

  task automatic do_update(bit t);
    if (pq_pc.size() > 0) begin
      upd_valid = 1; upd_pc = PC_W'(pq_pc.pop_front());
      upd_ckpt = CK_W'(pq_ck.pop_front()); upd_taken = t;
      step();
      upd_valid = 0;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: got 0 expected 1 (run completed)");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int saved, pc;
    for (int i = 0; i < 16; i++) m_lht[i] = 0;
    for (int i = 0; i < 64; i++) begin m_lc[i] = 1; m_gc[i] = 1; m_ch[i] = 1; end
    m_ghr = 0;
    r = $urandom(32'd11);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    lk_valid = 1; lk_pc = '0;
    #1;
    chk("R1 lk_taken", int'(lk_taken), 0);
    chk("R1 lk_ckpt", int'(lk_ckpt), 0);
    chk("R1 lk_ready", int'(lk_ready), 1);
    step();
    lk_valid = 0;
    // R8 R3: train one address taken until counters cross the threshold
    do_update(0);
    for (int k = 0; k < 8; k++) begin
      do_lookup(32'h40);
      do_update(1);
    end
    // R2: low address bits do not matter
    do_lookup(32'h43);
    do_update(1);
    // R6: squash after further speculation
    do_lookup(32'h44);
    saved = pq_ck[pq_ck.size() - 1];
    do_lookup(32'h48);
    do_lookup(32'h4c);
    sq_valid = 1; sq_ckpt = CK_W'(saved);
    step();
    sq_valid = 0;
    #1 chk("R6 restored history", int'(unc_ckpt) >> 3, saved >> 3);
    // R7: unconditional branch
    unc_valid = 1;
    step();
    unc_valid = 0;
    // R10: every request at once
    lk_valid = 1; unc_valid = 1; sq_valid = 1; sq_ckpt = '0;
    upd_valid = 1; upd_pc = 32'h40; upd_taken = 1; upd_ckpt = CK_W'(6);
    step();
    lk_valid = 0; unc_valid = 0; sq_valid = 0; upd_valid = 0;
    pq_pc.delete(); pq_ck.delete();
    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      r = $urandom();
      pc = 32'h100 + int'((r >> 4) & 7) * 4 + int'((r >> 7) & 3);
      lk_valid = r[0] | r[1];
      lk_pc = PC_W'(pc);
      unc_valid = r[21];
      if (pq_pc.size() > 0 && r[9]) begin
        upd_valid = 1;
        upd_pc = PC_W'(pq_pc[0]);
        upd_ckpt = CK_W'(pq_ck[0]);
        upd_taken = (((pq_pc[0] >> 2) & 1) != 0) ^ (r[14:11] == 4'd0);
        void'(pq_pc.pop_front());
        void'(pq_ck.pop_front());
      end
      if (pq_ck.size() > 0 && r[20:16] == 5'd0) begin
        sq_valid = 1;
        sq_ckpt = CK_W'(pq_ck[0]);
      end
      step();
      lk_valid = 0; unc_valid = 0; upd_valid = 0; sq_valid = 0;
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule